// File: doc/BRIEF.md
# Radio Transceiver State Controller

This block sequences a low-power radio transceiver through its operating states: a dark sleep state, a clock-only off state, a settling phase, a synthesizer-ready state, receive listening, busy receive and busy transmit. Software writes command codes as single-cycle strobes. A sleep pin level and a soft reset request sit alongside the commands. The block powers the analog regulator first. It enables the frequency synthesizer only after the regulator reports that it has settled. It raises one-cycle interrupt pulses when the synthesizer locks and when the transceiver wakes into the off state.

There are two kinds of shutdown. A plain off command given during a receive or transmit is held, and takes effect only when that activity ends. A forced off aborts at once. A forced return to the synthesizer-ready state also aborts at once, but it leaves the regulator and synthesizer running. Progress is reported only through a 5-bit status code that software polls. While the regulator is still settling, the status shows a transition code. The block also issues one-cycle clear requests to the frame buffer and cipher engine on entry to sleep, and a register-reset pulse on a soft reset. Commands are plain strobes and there is no data stream, so the block has no back-pressure.

Top module: `rf_state_ctrl`

## Requirements
- R1: After rst_n is released, status is 0x08 (off), areg_en and synth_en are low, and wake_irq pulses high for exactly the first cycle after the first clock edge.
- R2: With sleep_pin high in the off state, the next edge enters sleep (status 0x0F) and pulses fbuf_clear and cipher_clear for one cycle. A high sleep_pin in any other state is ignored.
- R3: In sleep every command is ignored. Driving sleep_pin low returns to off (0x08) on the next edge, with a one-cycle wake_irq.
- R4: reset_req in any state moves to off on the next edge, pulses regs_reset and wake_irq for one cycle, and drops areg_en and synth_en one edge later.
- R5: Command 0x09 in off gives status 0x1F (transition) and raises areg_en. synth_en rises only after reg_settled is seen with areg_en high, and status becomes 0x09 one edge after synth_en rises.
- R6: lock_irq is a one-cycle pulse issued when pll_locked is first seen while synth_en is high.
- R7: Command 0x06 in 0x09 gives status 0x06 on the next edge whether or not the synthesizer has locked. rx_enable is high only in 0x06 with a lock seen.
- R8: rx_frame_start in 0x06 with rx_enable gives 0x01 (busy receive), and rx_frame_end returns to 0x06. Command 0x02 in 0x09 gives 0x02 (busy transmit), and tx_done returns to 0x09.
- R9: Command 0x08 in 0x1F, 0x09 or 0x06 gives off on the next edge. In 0x01 or 0x02 it is held, and the block goes to off when the activity ends.
- R10: Command 0x03 (forced off) in 0x1F, 0x09, 0x06, 0x01 or 0x02 gives off on the next edge, and areg_en and synth_en fall one edge later.
- R11: Command 0x04 (forced synthesizer-ready) in 0x06, 0x01 or 0x02 gives 0x09 on the next edge, keeps areg_en and synth_en high, and discards a held off command.
- R12: Command codes are 0x00 none, 0x02 transmit, 0x03 forced off, 0x04 forced synthesizer-ready, 0x06 receive-on, 0x08 off and 0x09 synthesizer-ready. Any code not valid in the current state, including unlisted codes, leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 5 | Command code |
| sleep_pin | input | 1 | Sleep request level |
| reset_req | input | 1 | Soft reset request |
| reg_settled | input | 1 | Analog regulator settled |
| pll_locked | input | 1 | Synthesizer lock indication |
| rx_frame_start | input | 1 | Frame detected by the receiver |
| rx_frame_end | input | 1 | Received frame finished |
| tx_done | input | 1 | Transmission finished |
| status | output | 5 | Polled state code |
| areg_en | output | 1 | Analog regulator enable |
| synth_en | output | 1 | Frequency synthesizer enable |
| rx_enable | output | 1 | Frame reception allowed |
| lock_irq | output | 1 | Lock interrupt pulse |
| wake_irq | output | 1 | Wake interrupt pulse |
| fbuf_clear | output | 1 | Frame buffer clear pulse |
| cipher_clear | output | 1 | Cipher engine clear pulse |
| regs_reset | output | 1 | Register reset-value load pulse |

## Verification
A wrong internal state shows up on the status code on the edge after the command or event that caused it, because status is decoded straight from the state register. A fault in the power sequencing shows one edge later, on areg_en and synth_en. A lost or stuck held-off flag stays hidden until the busy activity ends, and then shows as the wrong status on that same edge. Sweeping every code in every reachable state therefore exposes transition faults within one cycle.

// File: rtl/rf_ctrl_pkg.sv
package rf_ctrl_pkg;
  localparam int STATUS_W = 5;
  localparam int CMD_W    = 5;

  localparam logic [STATUS_W-1:0] ST_BUSY_RX = 5'h01;
  localparam logic [STATUS_W-1:0] ST_BUSY_TX = 5'h02;
  localparam logic [STATUS_W-1:0] ST_RX_ON   = 5'h06;
  localparam logic [STATUS_W-1:0] ST_OFF     = 5'h08;
  localparam logic [STATUS_W-1:0] ST_PLL_ON  = 5'h09;
  localparam logic [STATUS_W-1:0] ST_SLEEP   = 5'h0F;
  localparam logic [STATUS_W-1:0] ST_TRANS   = 5'h1F;

  localparam logic [CMD_W-1:0] CMD_TX_START  = 5'h02;
  localparam logic [CMD_W-1:0] CMD_FORCE_OFF = 5'h03;
  localparam logic [CMD_W-1:0] CMD_FORCE_PLL = 5'h04;
  localparam logic [CMD_W-1:0] CMD_RX_ON     = 5'h06;
  localparam logic [CMD_W-1:0] CMD_OFF       = 5'h08;
  localparam logic [CMD_W-1:0] CMD_PLL_ON    = 5'h09;

  typedef enum logic [2:0] {
    S_OFF, S_SLEEP, S_SETTLE, S_PLL, S_RX, S_BUSY_RX, S_BUSY_TX
  } trx_state_e;

  typedef struct packed {
    logic tx_start;
    logic force_off;
    logic force_pll;
    logic rx_on;
    logic off;
    logic pll_on;
  } trx_cmd_t;

  function automatic logic [STATUS_W-1:0] status_of(trx_state_e s);
    case (s)
      S_OFF:     return ST_OFF;
      S_SLEEP:   return ST_SLEEP;
      S_SETTLE:  return ST_TRANS;
      S_PLL:     return ST_PLL_ON;
      S_RX:      return ST_RX_ON;
      S_BUSY_RX: return ST_BUSY_RX;
      S_BUSY_TX: return ST_BUSY_TX;
      default:   return ST_OFF;
    endcase
  endfunction
endpackage

// File: rtl/rf_cmd_decode.sv
module rf_cmd_decode
  import rf_ctrl_pkg::*;
(
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_code,
  output trx_cmd_t         cmd
);
  always_comb begin
    cmd = '0;
    if (cmd_valid) begin
      case (cmd_code)
        CMD_TX_START:  cmd.tx_start  = 1'b1;
        CMD_FORCE_OFF: cmd.force_off = 1'b1;
        CMD_FORCE_PLL: cmd.force_pll = 1'b1;
        CMD_RX_ON:     cmd.rx_on     = 1'b1;
        CMD_OFF:       cmd.off       = 1'b1;
        CMD_PLL_ON:    cmd.pll_on    = 1'b1;
        default:       cmd = '0;
      endcase
    end
  end
endmodule

// File: rtl/rf_power_seq.sv
module rf_power_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_req,
  input  logic reg_settled,
  input  logic pll_locked,
  output logic areg_en,
  output logic synth_en,
  output logic locked,
  output logic lock_irq
);
  logic areg_q, synth_q, lock_q, irq_q;
  logic lock_now;

  assign lock_now = pwr_req & synth_q & pll_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      areg_q  <= 1'b0;
      synth_q <= 1'b0;
      lock_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      areg_q  <= pwr_req;
      synth_q <= pwr_req & areg_q & (synth_q | reg_settled);
      lock_q  <= lock_now;
      irq_q   <= lock_now & ~lock_q;
    end
  end

  assign areg_en  = areg_q;
  assign synth_en = synth_q;
  assign locked   = lock_q;
  assign lock_irq = irq_q;
endmodule

// File: rtl/rf_state_fsm.sv
module rf_state_fsm
  import rf_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  trx_cmd_t            cmd,
  input  logic                sleep_pin,
  input  logic                reset_req,
  input  logic                synth_ready,
  input  logic                locked,
  input  logic                rx_frame_start,
  input  logic                rx_frame_end,
  input  logic                tx_done,
  output logic [STATUS_W-1:0] status,
  output logic                pwr_req,
  output logic                rx_enable,
  output logic                wake_irq,
  output logic                fbuf_clear,
  output logic                cipher_clear,
  output logic                regs_reset
);
  trx_state_e state_q, state_d;
  logic pend_q, pend_d;
  logic boot_q, wake_q, clr_q, rrst_q;
  logic any_off;

  assign any_off = cmd.force_off | cmd.off;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    if (reset_req) begin
      state_d = S_OFF;
      pend_d  = 1'b0;
    end else begin
      case (state_q)
        S_OFF: begin
          if (sleep_pin)       state_d = S_SLEEP;
          else if (cmd.pll_on) state_d = S_SETTLE;
        end
        S_SLEEP: if (!sleep_pin) state_d = S_OFF;
        S_SETTLE: begin
          if (any_off)          state_d = S_OFF;
          else if (synth_ready) state_d = S_PLL;
        end
        S_PLL: begin
          if (any_off)           state_d = S_OFF;
          else if (cmd.rx_on)    state_d = S_RX;
          else if (cmd.tx_start) state_d = S_BUSY_TX;
        end
        S_RX: begin
          if (any_off)                           state_d = S_OFF;
          else if (cmd.force_pll || cmd.pll_on)  state_d = S_PLL;
          else if (rx_frame_start && locked)     state_d = S_BUSY_RX;
        end
        S_BUSY_RX, S_BUSY_TX: begin
          if (cmd.force_off) begin
            state_d = S_OFF;
            pend_d  = 1'b0;
          end else if (cmd.force_pll) begin
            state_d = S_PLL;
            pend_d  = 1'b0;
          end else begin
            if (cmd.off) pend_d = 1'b1;
            if ((state_q == S_BUSY_RX && rx_frame_end) ||
                (state_q == S_BUSY_TX && tx_done)) begin
              pend_d = 1'b0;
              if (pend_q || cmd.off)        state_d = S_OFF;
              else if (state_q == S_BUSY_RX) state_d = S_RX;
              else                           state_d = S_PLL;
            end
          end
        end
        default: state_d = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      pend_q  <= 1'b0;
      boot_q  <= 1'b1;
      wake_q  <= 1'b0;
      clr_q   <= 1'b0;
      rrst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      boot_q  <= 1'b0;
      wake_q  <= boot_q | reset_req |
                 (state_q == S_SLEEP && state_d == S_OFF);
      clr_q   <= (state_q == S_OFF) && (state_d == S_SLEEP);
      rrst_q  <= reset_req;
    end
  end

  assign status       = status_of(state_q);
  assign pwr_req      = (state_q != S_OFF) && (state_q != S_SLEEP);
  assign rx_enable    = (state_q == S_RX) && locked;
  assign wake_irq     = wake_q;
  assign fbuf_clear   = clr_q;
  assign cipher_clear = clr_q;
  assign regs_reset   = rrst_q;
endmodule

// File: rtl/rf_state_ctrl.sv
module rf_state_ctrl
  import rf_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [CMD_W-1:0]    cmd_code,
  input  logic                sleep_pin,
  input  logic                reset_req,
  input  logic                reg_settled,
  input  logic                pll_locked,
  input  logic                rx_frame_start,
  input  logic                rx_frame_end,
  input  logic                tx_done,
  output logic [STATUS_W-1:0] status,
  output logic                areg_en,
  output logic                synth_en,
  output logic                rx_enable,
  output logic                lock_irq,
  output logic                wake_irq,
  output logic                fbuf_clear,
  output logic                cipher_clear,
  output logic                regs_reset
);
  trx_cmd_t cmd;
  logic     pwr_req;
  logic     locked;

  rf_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd       (cmd)
  );

  rf_power_seq u_pwr (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_req     (pwr_req),
    .reg_settled (reg_settled),
    .pll_locked  (pll_locked),
    .areg_en     (areg_en),
    .synth_en    (synth_en),
    .locked      (locked),
    .lock_irq    (lock_irq)
  );

  rf_state_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd            (cmd),
    .sleep_pin      (sleep_pin),
    .reset_req      (reset_req),
    .synth_ready    (synth_en),
    .locked         (locked),
    .rx_frame_start (rx_frame_start),
    .rx_frame_end   (rx_frame_end),
    .tx_done        (tx_done),
    .status         (status),
    .pwr_req        (pwr_req),
    .rx_enable      (rx_enable),
    .wake_irq       (wake_irq),
    .fbuf_clear     (fbuf_clear),
    .cipher_clear   (cipher_clear),
    .regs_reset     (regs_reset)
  );
endmodule

// File: rtl/rf_state_ctrl_chk.sv
module rf_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [4:0] cmd_code,
  input logic       sleep_pin,
  input logic       reset_req,
  input logic       rx_frame_end,
  input logic       tx_done,
  input logic [4:0] status,
  input logic       areg_en,
  input logic       synth_en,
  input logic       rx_enable,
  input logic       lock_irq,
  input logic       wake_irq,
  input logic       fbuf_clear,
  input logic       cipher_clear
);
  p_wake_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !reset_req) |=> !wake_irq);

  p_sleep_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 5'h08 && sleep_pin && !reset_req) |=>
      (status == 5'h0F && fbuf_clear && cipher_clear));

  p_sleep_dark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 5'h0F) |-> (!areg_en && !synth_en));

  p_soft_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (status == 5'h08 && wake_irq));

  p_synth_after_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    synth_en |-> areg_en);

  p_lock_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_irq |=> !lock_irq);

  p_rx_needs_synth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_enable |-> (synth_en && status == 5'h06));

  p_off_held_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 5'h08 && status == 5'h01 && !reset_req && !rx_frame_end)
      |=> status == 5'h01);

  p_off_held_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 5'h08 && status == 5'h02 && !reset_req && !tx_done)
      |=> status == 5'h02);

  p_force_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 5'h03 && !reset_req &&
     (status == 5'h1F || status == 5'h09 || status == 5'h06 ||
      status == 5'h01 || status == 5'h02)) |=> status == 5'h08);

  p_force_pll_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 5'h04 && !reset_req &&
     (status == 5'h06 || status == 5'h01 || status == 5'h02))
      |=> (status == 5'h09 && synth_en && areg_en));
endmodule

bind rf_state_ctrl rf_state_ctrl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_code     (cmd_code),
  .sleep_pin    (sleep_pin),
  .reset_req    (reset_req),
  .rx_frame_end (rx_frame_end),
  .tx_done      (tx_done),
  .status       (status),
  .areg_en      (areg_en),
  .synth_en     (synth_en),
  .rx_enable    (rx_enable),
  .lock_irq     (lock_irq),
  .wake_irq     (wake_irq),
  .fbuf_clear   (fbuf_clear),
  .cipher_clear (cipher_clear)
);

// File: tb/rf_state_ctrl_tb.sv
`timescale 1ns/1ps
module rf_state_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [4:0] cmd_code = '0;
  logic sleep_pin = 1'b0, reset_req = 1'b0, reg_settled = 1'b0, pll_locked = 1'b0;
  logic rx_frame_start = 1'b0, rx_frame_end = 1'b0, tx_done = 1'b0;
  logic [4:0] status;
  logic areg_en, synth_en, rx_enable, lock_irq, wake_irq;
  logic fbuf_clear, cipher_clear, regs_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rf_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .sleep_pin(sleep_pin), .reset_req(reset_req), .reg_settled(reg_settled),
    .pll_locked(pll_locked), .rx_frame_start(rx_frame_start),
    .rx_frame_end(rx_frame_end), .tx_done(tx_done), .status(status),
    .areg_en(areg_en), .synth_en(synth_en), .rx_enable(rx_enable),
    .lock_irq(lock_irq), .wake_irq(wake_irq), .fbuf_clear(fbuf_clear),
    .cipher_clear(cipher_clear), .regs_reset(regs_reset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_cmd(input logic [4:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    tick();
    cmd_valid = 1'b0;
    cmd_code  = '0;
  endtask

  // Expected status after code c in status st (reg_settled low in 0x1F).
  function automatic logic [4:0] exp_after(input logic [4:0] st, input logic [4:0] c);
    case (st)
      5'h08: return (c == 5'h09) ? 5'h1F : 5'h08;
      5'h0F: return 5'h0F;
      5'h1F: return (c == 5'h03 || c == 5'h08) ? 5'h08 : 5'h1F;
      5'h09: begin
        if (c == 5'h03 || c == 5'h08) return 5'h08;
        if (c == 5'h06) return 5'h06;
        if (c == 5'h02) return 5'h02;
        return 5'h09;
      end
      5'h06: begin
        if (c == 5'h03 || c == 5'h08) return 5'h08;
        if (c == 5'h04 || c == 5'h09) return 5'h09;
        return 5'h06;
      end
      default: begin
        if (c == 5'h03) return 5'h08;
        if (c == 5'h04) return 5'h09;
        return st;
      end
    endcase
  endfunction

  task automatic go_state(input logic [4:0] st);
    sleep_pin = 1'b0; rx_frame_start = 1'b0; rx_frame_end = 1'b0; tx_done = 1'b0;
    reg_settled = 1'b1; pll_locked = 1'b1;
    reset_req = 1'b1; tick(); reset_req = 1'b0; tick(2);
    case (st)
      5'h0F: begin sleep_pin = 1'b1; tick(); end
      5'h1F: begin reg_settled = 1'b0; send_cmd(5'h09); end
      5'h09, 5'h06, 5'h01, 5'h02: begin
        send_cmd(5'h09); tick(3);
        if (st == 5'h06 || st == 5'h01) send_cmd(5'h06);
        if (st == 5'h01) begin rx_frame_start = 1'b1; tick(); rx_frame_start = 1'b0; end
        if (st == 5'h02) send_cmd(5'h02);
      end
      default: ;
    endcase
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] states [7];
    states = '{5'h08, 5'h0F, 5'h1F, 5'h09, 5'h06, 5'h01, 5'h02};

    // R1 reset state
    tick(3);
    rst_n = 1'b1;
    check("R1 status after reset", status, 5'h08);
    check("R1 areg_en after reset", areg_en, 0);
    check("R1 synth_en after reset", synth_en, 0);
    tick();
    check("R1 boot wake pulse", wake_irq, 1);
    tick();
    check("R1 wake pulse ends", wake_irq, 0);

    // R5 / R6 / R7 power-up sequence
    send_cmd(5'h09);
    check("R5 transition code", status, 5'h1F);
    tick();
    check("R5 areg_en raised", areg_en, 1);
    check("R5 synth held before settle", synth_en, 0);
    tick(5);
    check("R5 still transition", status, 5'h1F);
    check("R5 synth still off", synth_en, 0);
    reg_settled = 1'b1;
    tick();
    check("R5 synth after settle", synth_en, 1);
    tick();
    check("R5 pll_on code", status, 5'h09);
    send_cmd(5'h06);
    check("R7 rx_on before lock", status, 5'h06);
    check("R7 rx_enable needs lock", rx_enable, 0);
    rx_frame_start = 1'b1; tick(); rx_frame_start = 1'b0;
    check("R7 frame start ignored before lock", status, 5'h06);
    pll_locked = 1'b1;
    tick();
    check("R6 lock pulse", lock_irq, 1);
    check("R7 rx_enable after lock", rx_enable, 1);
    tick();
    check("R6 lock pulse ends", lock_irq, 0);

    // R8 activity
    rx_frame_start = 1'b1; tick(); rx_frame_start = 1'b0;
    check("R8 busy receive", status, 5'h01);
    rx_frame_end = 1'b1; tick(); rx_frame_end = 1'b0;
    check("R8 back to rx_on", status, 5'h06);
    send_cmd(5'h09);
    check("R8 rx_on to pll_on", status, 5'h09);
    send_cmd(5'h02);
    check("R8 busy transmit", status, 5'h02);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    check("R8 back to pll_on", status, 5'h09);

    // R9 held off
    go_state(5'h02);
    send_cmd(5'h08);
    check("R9 off held in busy tx", status, 5'h02);
    tick(3);
    check("R9 still busy tx", status, 5'h02);
    tx_done = 1'b1; tick(); tx_done = 1'b0;
    check("R9 off after tx done", status, 5'h08);
    go_state(5'h01);
    send_cmd(5'h08);
    check("R9 off held in busy rx", status, 5'h01);
    rx_frame_end = 1'b1; tick(); rx_frame_end = 1'b0;
    check("R9 off after rx end", status, 5'h08);

    // R10 forced off
    go_state(5'h01);
    send_cmd(5'h03);
    check("R10 forced off", status, 5'h08);
    tick();
    check("R10 areg dropped", areg_en, 0);
    check("R10 synth dropped", synth_en, 0);

    // R11 forced pll_on
    go_state(5'h02);
    send_cmd(5'h04);
    check("R11 forced pll_on", status, 5'h09);
    check("R11 synth kept", synth_en, 1);
    tick();
    check("R11 areg kept", areg_en, 1);
    check("R11 synth still on", synth_en, 1);
    go_state(5'h01);
    send_cmd(5'h08);
    send_cmd(5'h04);
    tick(3);
    check("R11 pending off discarded", status, 5'h09);

    // R2 / R3 sleep
    go_state(5'h09);
    sleep_pin = 1'b1; tick();
    check("R2 sleep pin ignored in pll_on", status, 5'h09);
    go_state(5'h08);
    sleep_pin = 1'b1; tick();
    check("R2 sleep entered", status, 5'h0F);
    check("R2 fbuf clear", fbuf_clear, 1);
    check("R2 cipher clear", cipher_clear, 1);
    tick();
    check("R2 clear pulse ends", fbuf_clear, 0);
    send_cmd(5'h04);
    check("R3 forced pll ignored in sleep", status, 5'h0F);
    check("R3 regulator stays off", areg_en, 0);
    sleep_pin = 1'b0; tick();
    check("R3 wake to off", status, 5'h08);
    check("R3 wake pulse", wake_irq, 1);

    // R4 soft reset
    go_state(5'h02);
    reset_req = 1'b1; tick(); reset_req = 1'b0;
    check("R4 off after reset_req", status, 5'h08);
    check("R4 regs_reset pulse", regs_reset, 1);
    check("R4 wake pulse", wake_irq, 1);
    tick();
    check("R4 areg dropped", areg_en, 0);
    check("R4 regs_reset ends", regs_reset, 0);

    // R12 sweep of every code in every state
    for (int s = 0; s < 7; s++) begin
      for (int c = 0; c < 32; c++) begin
        go_state(states[s]);
        check("R12 setup", status, states[s]);
        send_cmd(c[4:0]);
        check($sformatf("R12 state 0x%0h code 0x%0h", states[s], c),
              status, exp_after(states[s], c[4:0]));
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule